// File: doc/BRIEF.md
# Fixed-point RGB to YUV stream converter

This block turns a stream of 8-bit unsigned red, green and blue samples into 8-bit luma and two chroma bytes. Each output channel is a weighted sum of the three colour samples. The weights are signed integers scaled by 2^15. The sum is divided by 2^15 with an arithmetic right shift, the chroma channels get a bias of 128, and every channel is clamped into the byte range.

A parameter sets how many pixels travel side by side in one beat. Each pixel has its own lane of arithmetic, and all lanes share one control path. Beats enter and leave through a valid/ready handshake. Three register stages hold the products, the sums and the final bytes. When the consumer holds back, the whole pipeline freezes in place.

Top module: `yuvStreamConv`

## Requirements
- R1: Luma byte Y = floor((9798*R + 19235*G + 3736*B) / 32768), clamped to 0..255.
- R2: Chroma byte U = floor((4221*B - 4784*R - 9437*G) / 32768) + 128, clamped to 0..255; over all byte inputs it stays within 17..160.
- R3: Chroma byte V = floor((20218*R - 16941*G - 3277*B) / 32768) + 128, clamped to 0..255.
- R4: A channel result above 255 is output as 255 and a result below 0 as 0. For example, pure red (R=255, G=0, B=0) gives V=255, and G=B=255 with R=0 gives V=0.
- R5: The division rounds toward minus infinity for negative sums. For example, R=0, G=B=255 gives U=87 (not 88) and Y=178.
- R6: With outReady high, a beat accepted at rising edge k is on outYuv with outValid high from just after edge k+2 (3 cycles after it is offered), and not before.
- R7: While outValid is high and outReady is low, outValid stays high, outYuv holds its value and inReady is low.
- R8: Lane i uses bits [24i+23:24i] of each bus. Input lane packing is R in 7:0, G in 15:8 and B in 23:16. Output lane packing is Y in 7:0, U in 15:8 and V in 23:16. Each lane depends only on its own input pixel.
- R9: During reset outValid is low and inReady is high.
- R10: Every accepted beat appears on the output exactly once, in acceptance order. Cycles with inValid low produce no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat offered |
| inReady | output | 1 | Converter takes the offered beat at the next edge |
| inRgb | input | LANES*24 | Packed input pixels, one per lane |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Consumer takes the output beat at the next edge |
| outYuv | output | LANES*24 | Packed converted pixels, one per lane |

## Verification
Acceptance of a new input beat and a stall at the output can fall in the same cycle. When outReady drops while a beat is offered and the last stage is full, inReady falls in that cycle, and the offered beat must be neither lost nor taken twice. The bench provokes this by toggling outReady at random while beats arrive with random gaps. A scoreboard pairs each delivered beat with the oldest one accepted, so any drop, duplicate or reorder shows up as a mismatch. A directed fill with outReady held low checks the frozen state and the release after it.

// File: rtl/yuvPkg.sv
package yuvPkg;
  localparam int SAMPLE_W    = 8;
  localparam int CH_N        = 3;
  localparam int PIX_W       = SAMPLE_W * CH_N;
  localparam int ACC_W       = 32;
  localparam int FRAC_BITS   = 15;
  localparam int CHROMA_BIAS = 1 << (SAMPLE_W - 1);
  localparam int SAT_MAX     = (1 << SAMPLE_W) - 1;
  localparam int U_LOW_REACH  = 17;
  localparam int U_HIGH_REACH = 160;

  typedef logic signed [ACC_W-1:0] acc_t;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageStb_t;

  // ch: 0 luma, 1 blue-difference, 2 red-difference; col: 0 red, 1 green, 2 blue
  function automatic acc_t coefOf(input int ch, input int col);
    acc_t k;
    k = '0;
    case (ch * CH_N + col)
      0: k = 9798;
      1: k = 19235;
      2: k = 3736;
      3: k = -4784;
      4: k = -9437;
      5: k = 4221;
      6: k = 20218;
      7: k = -16941;
      8: k = -3277;
      default: k = '0;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/yuvCtrl.sv
module yuvCtrl
  import yuvPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output stageStb_t stb
);
  logic v1Q, v2Q, v3Q;
  logic advC;

  // The whole pipe moves unless the last stage holds an untaken beat
  assign advC = !v3Q || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
      v3Q <= 1'b0;
    end else if (advC) begin
      v1Q <= inValid;
      v2Q <= v1Q;
      v3Q <= v2Q;
    end
  end

  // Data registers load only when a real beat moves into them
  always_comb begin
    stb.ld1 = advC && inValid;
    stb.ld2 = advC && v1Q;
    stb.ld3 = advC && v2Q;
  end

  assign inReady  = advC;
  assign outValid = v3Q;

  // R6
  accept_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> v1Q);

  // R6
  stage_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    v1Q && v2Q && outReady |=> v2Q && v3Q);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R10
  bubble_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !v2Q |=> !outValid);

  // R9
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_idle_chk: assert (!outValid && inReady);
    end
  end
endmodule

// File: rtl/yuvLane.sv
module yuvLane
  import yuvPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stageStb_t        stb,
  input  logic [PIX_W-1:0] rgbIn,
  output logic [PIX_W-1:0] yuvOut
);
  acc_t             prodQ   [CH_N][CH_N];
  acc_t             sumQ    [CH_N];
  acc_t             scaledC [CH_N];
  logic [SAMPLE_W-1:0] byteC [CH_N];
  logic [PIX_W-1:0] outQ;

  // Stage 1: nine signed products, samples zero-extended
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < CH_N; ch++)
        for (int col = 0; col < CH_N; col++)
          prodQ[ch][col] <= '0;
    end else if (stb.ld1) begin
      for (int ch = 0; ch < CH_N; ch++)
        for (int col = 0; col < CH_N; col++)
          prodQ[ch][col] <= coefOf(ch, col) * acc_t'(rgbIn[col*SAMPLE_W +: SAMPLE_W]);
    end
  end

  // Stage 2: one accumulated sum per output channel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < CH_N; ch++)
        sumQ[ch] <= '0;
    end else if (stb.ld2) begin
      for (int ch = 0; ch < CH_N; ch++)
        sumQ[ch] <= prodQ[ch][0] + prodQ[ch][1] + prodQ[ch][2];
    end
  end

  // Stage 3 logic: floor scaling, chroma bias, clamp
  always_comb begin
    for (int ch = 0; ch < CH_N; ch++) begin
      scaledC[ch] = (sumQ[ch] >>> FRAC_BITS) + ((ch == 0) ? acc_t'(0) : acc_t'(CHROMA_BIAS));
      if (scaledC[ch] < 0)
        byteC[ch] = '0;
      else if (scaledC[ch] > acc_t'(SAT_MAX))
        byteC[ch] = '1;
      else
        byteC[ch] = scaledC[ch][SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else if (stb.ld3) begin
      for (int ch = 0; ch < CH_N; ch++)
        outQ[ch*SAMPLE_W +: SAMPLE_W] <= byteC[ch];
    end
  end

  assign yuvOut = outQ;

  // R4
  v_sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld3 && (scaledC[2] > acc_t'(SAT_MAX)) |=> yuvOut[2*SAMPLE_W +: SAMPLE_W] == '1);

  // R4
  v_sat_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld3 && (scaledC[2] < 0) |=> yuvOut[2*SAMPLE_W +: SAMPLE_W] == '0);

  // R2
  u_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld3 |=> (int'(yuvOut[SAMPLE_W +: SAMPLE_W]) >= U_LOW_REACH) &&
                (int'(yuvOut[SAMPLE_W +: SAMPLE_W]) <= U_HIGH_REACH));
endmodule

// File: rtl/yuvDatapath.sv
module yuvDatapath
  import yuvPkg::*;
#(
  parameter  int LANES = 4,
  localparam int BUS_W = LANES * PIX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStb_t        stb,
  input  logic [BUS_W-1:0] rgbBus,
  output logic [BUS_W-1:0] yuvBus
);
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    yuvLane uLane (
      .clk    (clk),
      .rstN   (rstN),
      .stb    (stb),
      .rgbIn  (rgbBus[ln*PIX_W +: PIX_W]),
      .yuvOut (yuvBus[ln*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/yuvStreamConv.sv
module yuvStreamConv
  import yuvPkg::*;
#(
  parameter  int LANES = 4,
  localparam int BUS_W = LANES * PIX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [BUS_W-1:0] inRgb,
  output logic             outValid,
  input  logic             outReady,
  output logic [BUS_W-1:0] outYuv
);
  stageStb_t stb;

  yuvCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  yuvDatapath #(.LANES(LANES)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rgbBus (inRgb),
    .yuvBus (outYuv)
  );
endmodule

// File: tb/tb_yuvStreamConv.sv
module tb_yuvStreamConv;
  localparam int LANES = 4;
  localparam int BW    = LANES * 24;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [BW-1:0] inRgb = '0;
  logic inReady, outValid;
  logic [BW-1:0] outYuv;

  int nChecks = 0;
  int nFails  = 0;
  logic [BW-1:0] expQ [$];
  logic [BW-1:0] monExp;
  bit randReady = 1'b0;
  int readyPct  = 100;

  always #10 clk = ~clk;

  yuvStreamConv #(.LANES(LANES)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inRgb(inRgb),
    .outValid(outValid), .outReady(outReady), .outYuv(outYuv)
  );

  function automatic logic [7:0] clampByte(input int v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'd255;
    return v[7:0];
  endfunction

  function automatic logic [23:0] refPix(input logic [23:0] rgb);
    int r, g, b, y, u, v;
    r = int'(rgb[7:0]);
    g = int'(rgb[15:8]);
    b = int'(rgb[23:16]);
    y = (9798 * r + 19235 * g + 3736 * b) >>> 15;
    u = ((4221 * b - 4784 * r - 9437 * g) >>> 15) + 128;
    v = ((20218 * r - 16941 * g - 3277 * b) >>> 15) + 128;
    return {clampByte(v), clampByte(u), clampByte(y)};
  endfunction

  function automatic logic [BW-1:0] refBeat(input logic [BW-1:0] d);
    logic [BW-1:0] o;
    for (int ln = 0; ln < LANES; ln++)
      o[ln*24 +: 24] = refPix(d[ln*24 +: 24]);
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  task automatic sendBeat(input logic [BW-1:0] d);
    @(negedge clk);
    inValid = 1'b1;
    inRgb   = d;
    #5;
    while (!inReady) begin
      @(negedge clk);
      #5;
    end
    expQ.push_back(refBeat(d));
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Consumer readiness
  initial forever begin
    @(negedge clk);
    if (randReady) outReady = ($urandom_range(99) < readyPct);
  end

  // Scoreboard monitor: a transfer takes place at the next rising edge
  initial forever begin
    @(negedge clk);
    #5;
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "beat with nothing accepted", outYuv, '0);
      end else begin
        monExp = expQ.pop_front();
        check(outYuv === monExp, "R1 R2 R3 R8", "scoreboard beat", outYuv, monExp);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  localparam logic [BW-1:0] CORNER_IN  = 96'h000000_FFFFFF_FFFF00_0000FF;
  localparam logic [BW-1:0] CORNER_OUT = 96'h808000_8032FF_0057B2_FF5A4C;

  initial begin
    logic [BW-1:0] d;
    logic [BW-1:0] held;
    int waitCnt;

    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    check(outValid == 1'b0, "R9", "outValid in reset", BW'(outValid), '0);
    check(inReady == 1'b1, "R9", "inReady in reset", BW'(inReady), BW'(1));
    @(negedge clk);
    rstN = 1'b1;
    outReady = 1'b1;

    // Model against hand-derived corner values
    check(refBeat(CORNER_IN) === CORNER_OUT, "R4 R5", "bench model corners",
          refBeat(CORNER_IN), CORNER_OUT);

    // Latency with an empty pipe
    sendBeat(CORNER_IN);
    @(negedge clk);
    inValid = 1'b0;
    #5;
    check(outValid == 1'b0, "R6", "early valid after edge k", BW'(outValid), '0);
    @(posedge clk);
    #15;
    check(outValid == 1'b0, "R6", "early valid after edge k+1", BW'(outValid), '0);
    @(posedge clk);
    #15;
    check(outValid == 1'b1, "R6", "valid after edge k+2", BW'(outValid), BW'(1));
    check(outYuv === CORNER_OUT, "R4", "saturated V lanes", outYuv, CORNER_OUT);
    check(outYuv[47:40] == 8'd0 && outYuv[23:16] == 8'hFF, "R4", "V clamp bytes",
          outYuv, CORNER_OUT);
    check(outYuv[39:32] == 8'd87, "R5", "floor of negative U", BW'(outYuv[39:32]), BW'(87));
    idle(3);

    // Every black/white combination, rotated across lanes
    for (int k = 0; k < 8; k++) begin
      for (int ln = 0; ln < LANES; ln++) begin
        int m;
        m = (k + ln) % 8;
        d[ln*24 +: 24] = {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
      end
      sendBeat(d);
    end
    idle(6);

    // Stall: fill three stages with the consumer held off
    outReady = 1'b0;
    d = {$urandom, $urandom, $urandom};
    held = refBeat(d);
    sendBeat(d);
    sendBeat({$urandom, $urandom, $urandom});
    sendBeat({$urandom, $urandom, $urandom});
    idle(1);
    for (int c = 0; c < 4; c++) begin
      #5;
      check(outValid == 1'b1, "R7", "valid held in stall", BW'(outValid), BW'(1));
      check(inReady == 1'b0, "R7", "inReady low in stall", BW'(inReady), '0);
      check(outYuv === held, "R7", "data held in stall", outYuv, held);
      @(negedge clk);
    end
    outReady = 1'b1;
    idle(6);
    check(expQ.size() == 0, "R10", "stall drain", BW'(expQ.size()), '0);

    // Random traffic with random gaps and back-pressure
    randReady = 1'b1;
    readyPct  = 60;
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) == 0) begin
        idle(1);
      end else begin
        d = {$urandom, $urandom, $urandom};
        for (int ln = 0; ln < LANES; ln++) begin
          case ($urandom_range(3))
            0: d[ln*24 +: 8]  = 8'd0;
            1: d[ln*24 + 8 +: 8] = 8'd255;
            default: ;
          endcase
        end
        sendBeat(d);
      end
    end
    idle(1);
    randReady = 1'b0;
    @(negedge clk);
    outReady = 1'b1;
    waitCnt = 0;
    while (expQ.size() != 0 && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    idle(4);
    check(expQ.size() == 0, "R10", "all accepted beats delivered", BW'(expQ.size()), '0);
    #5;
    check(outValid == 1'b0, "R10", "no beat from idle cycles", BW'(outValid), '0);

    finishRun();
  end
endmodule